// File: doc/BRIEF.md
# Stored-Program Pulse Pattern Sequencer

This block plays a timed sequence of bit patterns onto a group of digital output lines. Each step of the sequence is one entry of an on-chip program. An entry is a pair of words at the same address: a hold time in clock cycles and the pattern to drive for that time. A host loads the entries through a simple write port while the block is idle. It also supplies the number of steps and a pattern to show between runs. After a start pulse, the block walks the program from address 0 on its own. It holds each pattern for its programmed time and then moves straight on to the next entry.

The duration memory and the pattern memory share one read pointer and have a one-cycle synchronous read. The output register of that read is used as a prefetch stage, so the entry after the active one is always waiting in registers. Each switch therefore happens on the cycle the running count expires, with no memory-latency gap. This holds even when every entry lasts a single cycle. When the last step ends, or when a stop pulse arrives, the lines return to the idle pattern.

Top module: `pulse_pattern_seq`

## Requirements
- R1: A host write with `hostWe` high stores `hostData` at `hostAddr` (11 bits). It goes to the duration memory when `hostSel` is 0 and to the pattern memory when `hostSel` is 1, but only while `busy` is low.
- R2: Host writes presented while `busy` is high change neither memory. A later run plays the contents written before the run.
- R3: A start pulse sampled at a clock edge while idle, with stop low, raises `busy` after that edge. The pattern of entry 0 appears on `pulseOut` after the following edge.
- R4: An entry with duration N holds its pattern on `pulseOut` for exactly N cycles. A duration of 0 behaves as 1.
- R5: Consecutive entries switch with no gap: the next pattern appears in the first cycle after the current duration expires, including runs of one-cycle entries.
- R6: A run plays `progLen` entries in address order. A `progLen` of 0 plays one entry, and values above the memory depth are limited to the depth.
- R7: On the edge where the last entry expires, `pulseOut` takes the idle pattern, `busy` falls and `done` is high for exactly one cycle.
- R8: A stop pulse sampled while busy ends the run on that edge. The idle pattern is driven, `busy` falls and `done` stays low. Stop wins over a simultaneous start.
- R9: Reset gives `pulseOut` = 0, `busy` = 0 and `done` = 0. While idle, `pulseOut` follows `idlePattern` one cycle later.
- R10: Every run begins at address 0, whatever the previous run ended on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 11 | Host write address (entry index) |
| hostSel | input | 1 | 0 selects the duration memory, 1 selects the pattern memory |
| hostData | input | 16 | Host write data |
| progLen | input | 12 | Number of entries in a run, sampled at start |
| idlePattern | input | 16 | Pattern driven between runs |
| startPulse | input | 1 | Begin a run from entry 0 |
| stopPulse | input | 1 | Abort the current run |
| pulseOut | output | 16 | Output lines |
| busy | output | 1 | High from the start edge until the run ends |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The bench compares every cycle of each run against a schedule it computes from the loaded durations. A wrong count would show up as an entry held a cycle short or a cycle long, and a prefetch with a stall would show up as a pattern repeated between one-cycle entries. Zero durations and a `progLen` of 0 are played and checked against their one-cycle and one-entry meanings. A design that decoded 0 literally would hang or wrap, or would play the whole memory. A write attempted in the middle of a run is followed by a second run, which shows whether that write leaked into the program. An abort is checked for an immediate return to idle with no completion pulse.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic hostWrite;   // commit the host word to the selected memory
    logic fetchFirst;  // read entry 0 into the prefetch registers
    logic advance;     // make the prefetched entry active and read the next one
    logic showIdle;    // drive the idle pattern on the output register
  } seqStrobe_t;
endpackage

// File: rtl/pulse_seq_datapath.sv
module pulse_seq_datapath
  import pulse_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostSel,
  input  logic [WORD_W-1:0] hostData,
  input  logic [WORD_W-1:0] idlePattern,
  output logic [WORD_W-1:0] nextDur,
  output logic [WORD_W-1:0] pulseOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] durMem [DEPTH];
  logic [WORD_W-1:0] patMem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] rdSel;
  logic [WORD_W-1:0] nextPat;

  // program store: written by the host only
  always_ff @(posedge clk) begin
    if (strobe.hostWrite && !hostSel) durMem[hostAddr] <= hostData;
    if (strobe.hostWrite &&  hostSel) patMem[hostAddr] <= hostData;
  end

  assign rdSel = strobe.fetchFirst ? '0 : rdPtr;

  // the synchronous read register doubles as the prefetch stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      nextDur  <= '0;
      nextPat  <= '0;
      pulseOut <= '0;
    end else begin
      if (strobe.fetchFirst || strobe.advance) begin
        nextDur <= durMem[rdSel];
        nextPat <= patMem[rdSel];
        rdPtr   <= rdSel + 1'b1;
      end
      if (strobe.advance)       pulseOut <= nextPat;
      else if (strobe.showIdle) pulseOut <= idlePattern;
    end
  end
endmodule

// File: rtl/pulse_seq_control.sv
module pulse_seq_control
  import pulse_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W:0]   progLen,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic [WORD_W-1:0] nextDur,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              done
);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(1 << ADDR_W);

  typedef enum logic [1:0] {IDLE, PRIME, RUN} seqState_t;

  seqState_t         state, stateNxt;
  logic [WORD_W-1:0] cnt, cntNxt;
  logic [LEN_W-1:0]  idx, idxNxt;
  logic [LEN_W-1:0]  lastIdx, lastIdxNxt;
  logic              doneNxt;
  logic [LEN_W-1:0]  lenEff;
  logic [WORD_W-1:0] durEff;

  assign lenEff = (progLen == '0) ? LEN_W'(1) :
                  (progLen > DEPTH_L) ? DEPTH_L : progLen;
  assign durEff = (nextDur == '0) ? WORD_W'(1) : nextDur;

  always_comb begin
    stateNxt   = state;
    cntNxt     = cnt;
    idxNxt     = idx;
    lastIdxNxt = lastIdx;
    doneNxt    = 1'b0;
    strobe     = '0;
    strobe.hostWrite = hostWe && (state == IDLE);
    unique case (state)
      IDLE: begin
        strobe.showIdle = 1'b1;
        if (startPulse && !stopPulse) begin
          strobe.fetchFirst = 1'b1;
          lastIdxNxt        = lenEff - 1'b1;
          stateNxt          = PRIME;
        end
      end
      PRIME: begin
        if (stopPulse) begin
          strobe.showIdle = 1'b1;
          stateNxt        = IDLE;
        end else begin
          strobe.advance = 1'b1;
          cntNxt         = durEff;
          idxNxt         = '0;
          stateNxt       = RUN;
        end
      end
      RUN: begin
        if (stopPulse) begin
          strobe.showIdle = 1'b1;
          stateNxt        = IDLE;
        end else if (cnt == WORD_W'(1)) begin
          if (idx == lastIdx) begin
            strobe.showIdle = 1'b1;
            doneNxt         = 1'b1;
            stateNxt        = IDLE;
          end else begin
            strobe.advance = 1'b1;
            cntNxt         = durEff;
            idxNxt         = idx + 1'b1;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: stateNxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      cnt     <= '0;
      idx     <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      idx     <= idxNxt;
      lastIdx <= lastIdxNxt;
      done    <= doneNxt;
    end
  end

  assign busy = (state != IDLE);
endmodule

// File: rtl/pulse_pattern_seq.sv
module pulse_pattern_seq
  import pulse_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostSel,
  input  logic [WORD_W-1:0] hostData,
  input  logic [ADDR_W:0]   progLen,
  input  logic [WORD_W-1:0] idlePattern,
  input  logic              startPulse,
  input  logic              stopPulse,
  output logic [WORD_W-1:0] pulseOut,
  output logic              busy,
  output logic              done
);
  seqStrobe_t        strobe;
  logic [WORD_W-1:0] nextDur;

  pulse_seq_control #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .progLen(progLen),
    .startPulse(startPulse), .stopPulse(stopPulse), .nextDur(nextDur),
    .strobe(strobe), .busy(busy), .done(done)
  );

  pulse_seq_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostSel(hostSel), .hostData(hostData), .idlePattern(idlePattern),
    .nextDur(nextDur), .pulseOut(pulseOut)
  );
endmodule

// File: rtl/pulse_pattern_seq_chk.sv
module pulse_pattern_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              stopPulse,
  input logic [WORD_W-1:0] idlePattern,
  input logic [WORD_W-1:0] pulseOut,
  input logic              busy,
  input logic              done
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_stop_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stopPulse) |=> (!busy && !done));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse && !stopPulse) |=> busy);

  assert_idle_track_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> (!busy && pulseOut == $past(idlePattern)));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind pulse_pattern_seq pulse_pattern_seq_chk #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
  .idlePattern(idlePattern), .pulseOut(pulseOut), .busy(busy), .done(done)
);

// File: tb/pulse_pattern_seq_test.sv
module pulse_pattern_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [10:0] hostAddr = '0;
  logic        hostSel = 1'b0;
  logic [15:0] hostData = '0;
  logic [11:0] progLen = '0;
  logic [15:0] idlePattern = 16'h00F0;
  logic        startPulse = 1'b0;
  logic        stopPulse = 1'b0;
  logic [15:0] pulseOut;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  // bench copy of the loaded program
  logic [15:0] durs [8];
  logic [15:0] pats [8];

  pulse_pattern_seq uut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostSel(hostSel), .hostData(hostData), .progLen(progLen),
    .idlePattern(idlePattern), .startPulse(startPulse), .stopPulse(stopPulse),
    .pulseOut(pulseOut), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic printSummary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic hostWrite(logic [10:0] a, logic sel, logic [15:0] d);
    hostWe = 1'b1; hostAddr = a; hostSel = sel; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic loadEntry(int i, logic [15:0] d, logic [15:0] p);
    durs[i] = d; pats[i] = p;
    hostWrite(11'(i), 1'b0, d);   // R1 duration memory
    hostWrite(11'(i), 1'b1, p);   // R1 pattern memory
  endtask

  function automatic int effDur(int i);
    return (durs[i] == 16'd0) ? 1 : int'(durs[i]);
  endfunction

  // expected output in cycle k after the start edge (k>=1)
  function automatic logic [15:0] expPat(int k, int n);
    int acc = 0;
    for (int j = 0; j < n; j++) begin
      if (k - 1 < acc + effDur(j)) return pats[j];
      acc += effDur(j);
    end
    return idlePattern;
  endfunction

  // start a run of n entries and check every cycle against the schedule
  task automatic runAndCheck(int n, string req, bit intrude);
    int total = 0;
    for (int j = 0; j < n; j++) total += effDur(j);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check({req, " R3 busy after start"}, busy, 1);
    check({req, " R3 idle before entry 0"}, pulseOut, idlePattern);
    for (int k = 1; k <= total + 2; k++) begin
      if (intrude && k == 1) begin
        hostWe = 1'b1; hostAddr = 11'd0; hostSel = 1'b1; hostData = 16'hDEAD;
      end
      @(negedge clk);
      if (intrude && k == 1) begin
        hostWe = 1'b1; hostAddr = 11'd0; hostSel = 1'b0; hostData = 16'd9;
      end
      if (intrude && k == 2) hostWe = 1'b0;
      check({req, " R4 R5 pattern schedule"}, pulseOut, expPat(k, n));
      check({req, " R7 busy"}, busy, (k <= total) ? 1 : 0);
      check({req, " R7 done"}, done, (k == total + 1) ? 1 : 0);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset pulseOut", pulseOut, 0);
    check("R9 reset busy", busy, 0);
    check("R9 reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle follows", pulseOut, 16'h00F0);
    idlePattern = 16'h0F0F;
    @(negedge clk);
    check("R9 idle change", pulseOut, 16'h0F0F);
  endtask

  task automatic testMixed();
    loadEntry(0, 16'd3, 16'h1111);
    loadEntry(1, 16'd1, 16'h2222);
    loadEntry(2, 16'd1, 16'h3333);
    loadEntry(3, 16'd2, 16'h4444);
    loadEntry(4, 16'd0, 16'h5555);  // R4 zero behaves as one
    loadEntry(5, 16'd4, 16'h6666);
    progLen = 12'd6;
    runAndCheck(6, "R6 mixed", 1'b0);
  endtask

  task automatic testAllShort();
    for (int i = 0; i < 6; i++) loadEntry(i, 16'd1, 16'(16'hA000 + i));
    progLen = 12'd6;
    runAndCheck(6, "R5 one-cycle run", 1'b0);
  endtask

  task automatic testWriteWhileBusy();
    loadEntry(0, 16'd2, 16'h0123);
    loadEntry(1, 16'd3, 16'h4567);
    progLen = 12'd2;
    runAndCheck(2, "R2 first run", 1'b1);
    // rerun: entry 0 must still hold the pre-run words, from address 0 (R10)
    runAndCheck(2, "R2 R10 rerun", 1'b0);
  endtask

  task automatic testStop();
    loadEntry(0, 16'd5, 16'hBEEF);
    loadEntry(1, 16'd5, 16'hCAFE);
    progLen = 12'd2;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 pattern before stop", pulseOut, 16'hBEEF);
    stopPulse = 1'b1;
    startPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    startPulse = 1'b0;
    check("R8 idle after stop", pulseOut, idlePattern);
    check("R8 busy after stop", busy, 0);
    check("R8 no done on stop", done, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 stays idle", pulseOut, idlePattern);
      check("R8 done stays low", done, 0);
    end
  endtask

  task automatic testZeroLen();
    loadEntry(0, 16'd2, 16'h7777);
    loadEntry(1, 16'd2, 16'h8888);
    progLen = 12'd0;
    runAndCheck(1, "R6 zero length", 1'b0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testMixed();
    testAllShort();
    testWriteWhileBusy();
    testStop();
    testZeroLen();
    printSummary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    printSummary();
    $finish;
  end
endmodule